// File: doc/BRIEF.md
# Two-Cycle Command Bus Decoder

This block sits on the device side of a 14-bit command bus that comes with an active-low select line. Both are sampled on every rising clock edge. A cycle with the select line low starts a command. The opcode is a prefix code of variable length carried on the lowest bus lines. Commands that carry no address are complete in that one cycle. Commands that carry an address or register data also use the following cycle, in which the select line is high. The block holds the first half in a register, joins it with the second half, and emits one decoded command together with its fields.

Every decoded command appears on a registered output with a one-cycle valid strobe. The strobe rises on the clock edge after the last bus cycle of the command has been sampled. Reserved encodings raise an illegal pulse instead of a command. A new command that starts while a second half is still awaited raises a sequence-abort pulse, and the new cycle is decoded as a fresh start. Output fields that do not belong to the decoded operation are forced to zero.

Top module: `cmdbus_decoder`

## Requirements
- R1: During and directly after a synchronous active-high reset, every output is zero.
- R2: A start cycle (sel_n=0) whose bus lines CA0..CA4 read 1,1,1,1,1 is a no-op. It gives cmd_valid=1 with cmd_op=16 on the next clock edge, all fields zero. cmd_valid is never high with cmd_op=0. Operation codes: 1 activate, 2 read, 3 write, 4 pattern write, 5 register write, 6 register read, 7 reference-level set, 8 refresh all banks, 9 refresh same bank, 10 close all banks, 11 close same bank, 12 close one bank, 13 self-refresh entry, 14 power-down entry, 15 sub-command, 16 no-op.
- R3: CA0=0, CA1=0 starts an activate. Start cycle: row[3:0]=CA5..CA2, bank=CA7..CA6, bgroup=CA10..CA8, chip[2:0]=CA13..CA11. Second cycle: row[16:4]=CA12..CA0, row[17]=CA13, chip[3]=0.
- R4: CA0..CA4 = 1,0,1,1,0 is a write and 1,0,1,1,1 is a read, each with burst_short=CA5. Pattern write is 1,0,0,1,0 and needs CA5=1; its burst_short is 0. All three take bank, bgroup and chip[2:0] as in R3. In the second cycle they take column=CA8..CA1, auto_pre=CA10 and chip[3]=CA13. Only a write also takes wr_partial=CA11.
- R5: 1,0,1,0,0 is a register write and 1,0,1,0,1 is a register read. Each takes modereg_addr=CA12..CA5 in the start cycle and reg_bank_sel=CA10 in the second cycle. Only a register write takes modereg_data=CA7..CA0 in the second cycle.
- R6: 1,1,0,0,1 is a refresh and 1,1,0,1,0 is a close-all. In both, CA10=0 selects all banks (op 8 or 10) and CA10=1 selects same bank (op 9 or 11, bank=CA7..CA6). 1,1,0,1,1 closes one bank (op 12, bank, bgroup as in R3). All three take chip[3]=CA5 and chip[2:0]=CA13..CA11.
- R7: 1,1,1,0,1 with CA9=0 is self-refresh entry (op 13). With CA9=1 it is power-down entry (op 14), and term_hold=CA10.
- R8: 1,1,1,1,0 (op 15) and 1,1,0,0,0 (op 7) put CA12..CA5 on sub_code.
- R9: A cycle with sel_n=1 and no pending start produces no valid, no illegal and no abort.
- R10: The start encodings CA0..CA4 = 0,1,x,x,x; 1,0,0,0,x; 1,0,0,1,1; 1,1,1,0,0, and a pattern write with CA5=0, each give illegal=1 on the next edge. They give no cmd_valid and start no second half.
- R11: A start cycle that arrives while a second half is pending drops the pending command. It gives seq_abort=1 on the next edge and is itself decoded as a fresh start cycle.
- R12: Any output field that the decoded operation does not define is zero. When cmd_valid=0, cmd_op and all fields are zero.
- R13: The cycle after a two-cycle start with sel_n=1 completes it: cmd_valid rises for exactly one cycle on the next edge. The pending state is then gone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_n | input | 1 | Active-low command select |
| cmd_bus | input | 14 | Command/address lines CA0..CA13 |
| cmd_valid | output | 1 | One-cycle strobe for a decoded command |
| cmd_op | output | 5 | Operation code (see R2) |
| row | output | 18 | Row address, bit 17 is the extension bit |
| bank | output | 2 | Bank |
| bgroup | output | 3 | Bank group |
| chip | output | 4 | Stacked-die select |
| column | output | 8 | Column bits 3 to 10 |
| auto_pre | output | 1 | Close row after access |
| burst_short | output | 1 | Burst length other than sixteen |
| wr_partial | output | 1 | Partial write |
| reg_bank_sel | output | 1 | Second register bank select |
| term_hold | output | 1 | Termination stays on in power-down |
| modereg_addr | output | 8 | Register address |
| modereg_data | output | 8 | Register write data |
| sub_code | output | 8 | Sub-command or reference-level code |
| illegal | output | 1 | Reserved encoding seen |
| seq_abort | output | 1 | Pending second half dropped |

## Verification
The bench starts a two-cycle command and then drives a new start cycle in the slot where the second half belongs. A decoder that merged that cycle as a second half would report a wrong command and miss the abort, and one that threw it away would lose a command. It steps through every reserved prefix and a pattern write with its fixed bit cleared. A decoder with a loose prefix match would emit a command there, or would wait for a second half that never comes. It sets every bus bit that a given operation ignores and checks that those bits do not leak into unrelated fields. It also checks that a second half with select high, arriving when nothing is pending, stays silent.

// File: rtl/cmdbus_pkg.sv
package cmdbus_pkg;
    localparam int CA_W    = 14;
    localparam int ROW_W   = 18;
    localparam int BANK_W  = 2;
    localparam int BG_W    = 3;
    localparam int CHIP_W  = 4;
    localparam int COL_W   = 8;
    localparam int BYTE_W  = 8;
    localparam int OP_W    = 5;
    localparam int PFX_W   = 4;

    typedef enum logic [OP_W-1:0] {
        OP_NONE     = 5'd0,
        OP_ACT      = 5'd1,
        OP_RD       = 5'd2,
        OP_WR       = 5'd3,
        OP_WRPAT    = 5'd4,
        OP_MRW      = 5'd5,
        OP_MRR      = 5'd6,
        OP_VREF     = 5'd7,
        OP_REF_ALL  = 5'd8,
        OP_REF_SB   = 5'd9,
        OP_PRE_ALL  = 5'd10,
        OP_PRE_SB   = 5'd11,
        OP_PRE_BANK = 5'd12,
        OP_SRE      = 5'd13,
        OP_PDE      = 5'd14,
        OP_MPC      = 5'd15,
        OP_NOP      = 5'd16
    } op_e;

    typedef struct packed {
        op_e                op;
        logic [ROW_W-1:0]   row;
        logic [BANK_W-1:0]  bank;
        logic [BG_W-1:0]    bgroup;
        logic [CHIP_W-1:0]  chip;
        logic [COL_W-1:0]   column;
        logic               auto_pre;
        logic               burst_short;
        logic               wr_partial;
        logic               reg_bank_sel;
        logic               term_hold;
        logic [BYTE_W-1:0]  modereg_addr;
        logic [BYTE_W-1:0]  modereg_data;
        logic [BYTE_W-1:0]  sub_code;
    } cmd_t;

    // Prefix patterns for CA1..CA4 (CA0=1), written CA1 first.
    localparam logic [PFX_W-1:0] PFX_WR     = 4'b0110;
    localparam logic [PFX_W-1:0] PFX_RD     = 4'b0111;
    localparam logic [PFX_W-1:0] PFX_WRPAT  = 4'b0010;
    localparam logic [PFX_W-1:0] PFX_MRW    = 4'b0100;
    localparam logic [PFX_W-1:0] PFX_MRR    = 4'b0101;
    localparam logic [PFX_W-1:0] PFX_VREF   = 4'b1000;
    localparam logic [PFX_W-1:0] PFX_REF    = 4'b1001;
    localparam logic [PFX_W-1:0] PFX_PREALL = 4'b1010;
    localparam logic [PFX_W-1:0] PFX_PRE    = 4'b1011;
    localparam logic [PFX_W-1:0] PFX_PWR    = 4'b1101;
    localparam logic [PFX_W-1:0] PFX_MPC    = 4'b1110;
    localparam logic [PFX_W-1:0] PFX_NOP    = 4'b1111;

    function automatic logic takes_two(op_e op);
        return (op == OP_ACT) || (op == OP_RD) || (op == OP_WR) ||
               (op == OP_WRPAT) || (op == OP_MRW) || (op == OP_MRR);
    endfunction

    // Bank, bank group and low chip bits share one layout in start cycles.
    function automatic cmd_t addr_start(op_e op, logic [CA_W-1:0] ca);
        cmd_t c;
        c = '0;
        c.op        = op;
        c.bank      = ca[7:6];
        c.bgroup    = ca[10:8];
        c.chip[2:0] = ca[13:11];
        return c;
    endfunction

    function automatic logic [PFX_W-1:0] prefix_of(logic [CA_W-1:0] ca);
        return {ca[1], ca[2], ca[3], ca[4]};
    endfunction
endpackage

// File: rtl/cmdbus_first_half.sv
module cmdbus_first_half
    import cmdbus_pkg::*;
(
    input  logic [CA_W-1:0] ca,
    output cmd_t            start_cmd,
    output logic            reserved
);
    logic [PFX_W-1:0] pfx;

    assign pfx = prefix_of(ca);

    always_comb begin
        start_cmd = '0;
        reserved  = 1'b0;
        if (!ca[0]) begin
            if (ca[1]) begin
                reserved = 1'b1;
            end else begin
                start_cmd          = addr_start(OP_ACT, ca);
                start_cmd.row[3:0] = ca[5:2];
            end
        end else begin
            case (pfx)
                PFX_WR: begin
                    start_cmd             = addr_start(OP_WR, ca);
                    start_cmd.burst_short = ca[5];
                end
                PFX_RD: begin
                    start_cmd             = addr_start(OP_RD, ca);
                    start_cmd.burst_short = ca[5];
                end
                PFX_WRPAT: begin
                    if (ca[5]) start_cmd = addr_start(OP_WRPAT, ca);
                    else       reserved  = 1'b1;
                end
                PFX_MRW: begin
                    start_cmd.op           = OP_MRW;
                    start_cmd.modereg_addr = ca[12:5];
                end
                PFX_MRR: begin
                    start_cmd.op           = OP_MRR;
                    start_cmd.modereg_addr = ca[12:5];
                end
                PFX_VREF: begin
                    start_cmd.op       = OP_VREF;
                    start_cmd.sub_code = ca[12:5];
                end
                PFX_MPC: begin
                    start_cmd.op       = OP_MPC;
                    start_cmd.sub_code = ca[12:5];
                end
                PFX_REF, PFX_PREALL: begin
                    if (pfx == PFX_REF) start_cmd.op = ca[10] ? OP_REF_SB : OP_REF_ALL;
                    else                start_cmd.op = ca[10] ? OP_PRE_SB : OP_PRE_ALL;
                    start_cmd.chip = {ca[5], ca[13:11]};
                    if (ca[10]) start_cmd.bank = ca[7:6];
                end
                PFX_PRE: begin
                    start_cmd         = addr_start(OP_PRE_BANK, ca);
                    start_cmd.chip[3] = ca[5];
                end
                PFX_PWR: begin
                    if (ca[9]) begin
                        start_cmd.op        = OP_PDE;
                        start_cmd.term_hold = ca[10];
                    end else begin
                        start_cmd.op = OP_SRE;
                    end
                end
                PFX_NOP: start_cmd.op = OP_NOP;
                default: reserved = 1'b1;
            endcase
        end
    end

    always_comb begin
        if (reserved) assert (start_cmd.op == OP_NONE)
            else $error("assert_reserved_no_op_R10: reserved start produced op %0d", start_cmd.op);
    end
endmodule

// File: rtl/cmdbus_pending.sv
module cmdbus_pending
    import cmdbus_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  cmd_t d,
    output logic held_vld,
    output cmd_t held
);
    always_ff @(posedge clk) begin
        if (rst) begin
            held_vld <= 1'b0;
            held     <= '0;
        end else begin
            held_vld <= load;
            if (load) held <= d;
        end
    end

    a_held_two_cycle_R13: assert property (@(posedge clk) disable iff (rst)
        held_vld |-> takes_two(held.op));
endmodule

// File: rtl/cmdbus_merge.sv
module cmdbus_merge
    import cmdbus_pkg::*;
(
    input  cmd_t            first,
    input  logic [CA_W-1:0] ca,
    output cmd_t            whole
);
    always_comb begin
        whole = first;
        case (first.op)
            OP_ACT: begin
                whole.row[16:4] = ca[12:0];
                whole.row[17]   = ca[13];
            end
            OP_RD, OP_WR, OP_WRPAT: begin
                whole.column   = ca[8:1];
                whole.auto_pre = ca[10];
                whole.chip[3]  = ca[13];
                if (first.op == OP_WR) whole.wr_partial = ca[11];
            end
            OP_MRW: begin
                whole.modereg_data = ca[7:0];
                whole.reg_bank_sel = ca[10];
            end
            OP_MRR: whole.reg_bank_sel = ca[10];
            default: ;
        endcase
    end
endmodule

// File: rtl/cmdbus_decoder.sv
module cmdbus_decoder
    import cmdbus_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sel_n,
    input  logic [CA_W-1:0]      cmd_bus,
    output logic                 cmd_valid,
    output logic [OP_W-1:0]      cmd_op,
    output logic [ROW_W-1:0]     row,
    output logic [BANK_W-1:0]    bank,
    output logic [BG_W-1:0]      bgroup,
    output logic [CHIP_W-1:0]    chip,
    output logic [COL_W-1:0]     column,
    output logic                 auto_pre,
    output logic                 burst_short,
    output logic                 wr_partial,
    output logic                 reg_bank_sel,
    output logic                 term_hold,
    output logic [BYTE_W-1:0]    modereg_addr,
    output logic [BYTE_W-1:0]    modereg_data,
    output logic [BYTE_W-1:0]    sub_code,
    output logic                 illegal,
    output logic                 seq_abort
);
    cmd_t start_cmd, held, whole, out_d, out_q;
    logic reserved, held_vld, start_now, load_two, emit_d;
    logic valid_q, illegal_q, abort_q;

    cmdbus_first_half u_first (.ca(cmd_bus), .start_cmd(start_cmd), .reserved(reserved));

    assign start_now = !sel_n;
    assign load_two  = start_now && !reserved && takes_two(start_cmd.op);

    cmdbus_pending u_pend (
        .clk(clk), .rst(rst), .load(load_two), .d(start_cmd),
        .held_vld(held_vld), .held(held)
    );

    cmdbus_merge u_merge (.first(held), .ca(cmd_bus), .whole(whole));

    always_comb begin
        out_d  = '0;
        emit_d = 1'b0;
        if (held_vld && sel_n) begin
            out_d  = whole;
            emit_d = 1'b1;
        end else if (start_now && !reserved && !takes_two(start_cmd.op)) begin
            out_d  = start_cmd;
            emit_d = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q     <= '0;
            valid_q   <= 1'b0;
            illegal_q <= 1'b0;
            abort_q   <= 1'b0;
        end else begin
            out_q     <= out_d;
            valid_q   <= emit_d;
            illegal_q <= start_now && reserved;
            abort_q   <= start_now && held_vld;
        end
    end

    assign cmd_valid    = valid_q;
    assign cmd_op       = out_q.op;
    assign row          = out_q.row;
    assign bank         = out_q.bank;
    assign bgroup       = out_q.bgroup;
    assign chip         = out_q.chip;
    assign column       = out_q.column;
    assign auto_pre     = out_q.auto_pre;
    assign burst_short  = out_q.burst_short;
    assign wr_partial   = out_q.wr_partial;
    assign reg_bank_sel = out_q.reg_bank_sel;
    assign term_hold    = out_q.term_hold;
    assign modereg_addr = out_q.modereg_addr;
    assign modereg_data = out_q.modereg_data;
    assign sub_code     = out_q.sub_code;
    assign illegal      = illegal_q;
    assign seq_abort    = abort_q;

    assert_seq_abort_R11: assert property (@(posedge clk) disable iff (rst)
        (held_vld && !sel_n) |=> seq_abort);
    assert_second_half_R13: assert property (@(posedge clk) disable iff (rst)
        (held_vld && sel_n) |=> (cmd_valid && takes_two(op_e'(cmd_op))));
    assert_deselect_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (!held_vld && sel_n) |=> (!cmd_valid && !illegal && !seq_abort));
    assert_valid_illegal_excl_R10: assert property (@(posedge clk) disable iff (rst)
        !(cmd_valid && illegal));
    assert_valid_has_op_R2: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> (cmd_op != OP_NONE));
    assert_idle_fields_zero_R12: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |-> (cmd_op == '0 && row == '0 && column == '0 && sub_code == '0));
endmodule

// File: tb/cmdbus_decoder_tb.sv
module cmdbus_decoder_tb_top;
    import cmdbus_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sel_n = 1'b1;
    logic [CA_W-1:0] cmd_bus = '0;
    logic cmd_valid, auto_pre, burst_short, wr_partial, reg_bank_sel, term_hold, illegal, seq_abort;
    logic [OP_W-1:0] cmd_op;
    logic [ROW_W-1:0] row;
    logic [BANK_W-1:0] bank;
    logic [BG_W-1:0] bgroup;
    logic [CHIP_W-1:0] chip;
    logic [COL_W-1:0] column;
    logic [BYTE_W-1:0] modereg_addr, modereg_data, sub_code;

    int checks = 0;
    int fails = 0;
    int cycles = 0;

    bit   m_pend = 0;
    cmd_t m_held = '0;

    always #2 clk = ~clk;

    cmdbus_decoder dut_i (
        .clk(clk), .rst(rst), .sel_n(sel_n), .cmd_bus(cmd_bus),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .row(row), .bank(bank), .bgroup(bgroup),
        .chip(chip), .column(column), .auto_pre(auto_pre), .burst_short(burst_short),
        .wr_partial(wr_partial), .reg_bank_sel(reg_bank_sel), .term_hold(term_hold),
        .modereg_addr(modereg_addr), .modereg_data(modereg_data), .sub_code(sub_code),
        .illegal(illegal), .seq_abort(seq_abort)
    );

    // Builds a bus word; code lists CA0 first (MSB) to CA4 (LSB).
    function automatic logic [CA_W-1:0] mk(logic [4:0] code, logic [8:0] hi);
        return {hi, code[0], code[1], code[2], code[3], code[4]};
    endfunction

    function automatic string req_of(logic [OP_W-1:0] op);
        case (op)
            5'd1:                 return "R3";
            5'd2, 5'd3, 5'd4:     return "R4";
            5'd5, 5'd6:           return "R5";
            5'd7, 5'd15:          return "R8";
            5'd8, 5'd9, 5'd10, 5'd11, 5'd12: return "R6";
            5'd13, 5'd14:         return "R7";
            5'd16:                return "R2";
            default:              return "R9";
        endcase
    endfunction

    // Expected start-cycle decode straight from the requirement text.
    function automatic void model_start(input logic [CA_W-1:0] b, output cmd_t c, output bit bad);
        logic [4:0] k;
        c = '0; bad = 0;
        k = {b[0], b[1], b[2], b[3], b[4]};
        if (k[4:3] == 2'b00) begin
            c.op = OP_ACT; c.row[3:0] = b[5:2];
            c.bank = b[7:6]; c.bgroup = b[10:8]; c.chip[2:0] = b[13:11];
        end else if (k[4:3] == 2'b01) bad = 1;
        else begin
            case (k)
                5'b10110, 5'b10111, 5'b10010: begin
                    c.op = (k == 5'b10110) ? OP_WR : (k == 5'b10111) ? OP_RD : OP_WRPAT;
                    c.bank = b[7:6]; c.bgroup = b[10:8]; c.chip[2:0] = b[13:11];
                    if (k != 5'b10010) c.burst_short = b[5];
                    else if (!b[5]) begin c = '0; bad = 1; end
                end
                5'b10100: begin c.op = OP_MRW; c.modereg_addr = b[12:5]; end
                5'b10101: begin c.op = OP_MRR; c.modereg_addr = b[12:5]; end
                5'b11000: begin c.op = OP_VREF; c.sub_code = b[12:5]; end
                5'b11110: begin c.op = OP_MPC; c.sub_code = b[12:5]; end
                5'b11001, 5'b11010: begin
                    if (k == 5'b11001) c.op = b[10] ? OP_REF_SB : OP_REF_ALL;
                    else               c.op = b[10] ? OP_PRE_SB : OP_PRE_ALL;
                    c.chip = {b[5], b[13:11]};
                    if (b[10]) c.bank = b[7:6];
                end
                5'b11011: begin
                    c.op = OP_PRE_BANK; c.chip = {b[5], b[13:11]};
                    c.bank = b[7:6]; c.bgroup = b[10:8];
                end
                5'b11101: begin
                    c.op = b[9] ? OP_PDE : OP_SRE;
                    if (b[9]) c.term_hold = b[10];
                end
                5'b11111: c.op = OP_NOP;
                default: bad = 1;
            endcase
        end
    endfunction

    function automatic cmd_t model_second(cmd_t h, logic [CA_W-1:0] b);
        cmd_t c = h;
        if (h.op == OP_ACT) c.row[17:4] = b[13:0];
        else if (h.op == OP_MRW || h.op == OP_MRR) begin
            c.reg_bank_sel = b[10];
            if (h.op == OP_MRW) c.modereg_data = b[7:0];
        end else begin
            c.column = b[8:1]; c.auto_pre = b[10]; c.chip[3] = b[13];
            if (h.op == OP_WR) c.wr_partial = b[11];
        end
        return c;
    endfunction

    function automatic bit is_two(op_e op);
        return op == OP_ACT || op == OP_RD || op == OP_WR || op == OP_WRPAT ||
               op == OP_MRW || op == OP_MRR;
    endfunction

    task automatic check_bit(string tag, logic got, logic exp, string what);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0b expected=%0b", tag, what, got, exp);
        end
    endtask

    task automatic step(bit s, logic [CA_W-1:0] b, string tag);
        cmd_t exp, fc, got;
        bit ev, eill, eab, bad;
        @(negedge clk);
        sel_n = s; cmd_bus = b;
        exp = '0; ev = 0; eill = 0; eab = 0;
        if (!s) begin
            eab = m_pend;
            m_pend = 0;
            model_start(b, fc, bad);
            if (bad) eill = 1;
            else if (is_two(fc.op)) begin m_pend = 1; m_held = fc; end
            else begin exp = fc; ev = 1; end
        end else if (m_pend) begin
            exp = model_second(m_held, b); ev = 1; m_pend = 0;
        end
        @(posedge clk); #1;
        got = {op_e'(cmd_op), row, bank, bgroup, chip, column, auto_pre, burst_short,
               wr_partial, reg_bank_sel, term_hold, modereg_addr, modereg_data, sub_code};
        check_bit(tag == "" ? req_of(exp.op) : tag, cmd_valid, ev, "cmd_valid");
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s fields actual=%h expected=%h", tag == "" ? req_of(exp.op) : tag, got, exp);
        end
        check_bit(tag == "" ? "R10" : tag, illegal, eill, "illegal");
        check_bit(tag == "" ? "R11" : tag, seq_abort, eab, "seq_abort");
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                fails++;
                $display("FAIL R13 watchdog actual=hung expected=done");
                $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'h5EED_0C0D));
        repeat (3) @(posedge clk);
        #1;
        check_bit("R1", cmd_valid, 1'b0, "valid in reset");
        checks++;
        if ({cmd_op, row, column, modereg_addr, modereg_data, sub_code, chip, illegal, seq_abort} !== '0) begin
            fails++;
            $display("FAIL R1 outputs in reset actual=nonzero expected=0");
        end
        @(negedge clk); rst = 1'b0;
        step(1, '1, "R9");                                   // deselect, bus all ones
        step(0, mk(5'b00000, 9'h1A5), "R3");                 // activate start
        step(1, 14'h2B7C, "R3");                             // activate second
        step(0, mk(5'b10110, 9'h1FF), "R4");                 // write, short burst
        step(1, 14'h3FFF, "R4");
        step(0, mk(5'b10111, 9'h0C2), "R4");                 // read
        step(1, 14'h3FFF, "R4");                             // wr_partial must stay 0
        step(0, mk(5'b10010, 9'h0F1), "R4");                 // pattern write
        step(1, 14'h2A5A, "R4");
        step(0, mk(5'b10100, 9'h155), "R5");                 // register write
        step(1, 14'h04C3, "R5");
        step(0, mk(5'b10101, 9'h0AA), "R5");                 // register read
        step(1, 14'h3FFF, "R5");                             // data must stay 0
        step(0, mk(5'b11001, 9'h1FF), "R6");                 // refresh same bank
        step(0, mk(5'b11001, 9'h1DF), "R6");                 // refresh all banks
        step(0, mk(5'b11010, 9'h0E3), "R6");                 // close all
        step(0, mk(5'b11011, 9'h16D), "R6");                 // close one bank
        step(0, mk(5'b11101, 9'h1F0), "R7");                 // power-down, term on
        step(0, mk(5'b11101, 9'h1EF), "R7");                 // self-refresh
        step(0, mk(5'b11110, 9'h1A5), "R8");
        step(0, mk(5'b11000, 9'h05A), "R8");
        step(0, mk(5'b11111, 9'h1FF), "R12");                // no-op, other bits ignored
        step(0, mk(5'b01101, 9'h000), "R10");
        step(0, mk(5'b10001, 9'h000), "R10");
        step(0, mk(5'b10011, 9'h000), "R10");
        step(0, mk(5'b11100, 9'h000), "R10");
        step(0, mk(5'b10010, 9'h1FE), "R10");                // pattern write, CA5=0
        step(1, 14'h3FFF, "R10");                            // no second half started
        step(0, mk(5'b00000, 9'h0FF), "R11");                // activate start
        step(0, mk(5'b10111, 9'h003), "R11");                // read start aborts it
        step(1, 14'h1234, "R11");                            // read completes
        step(0, mk(5'b10100, 9'h111), "R13");
        step(1, 14'h00FF, "R13");
        step(1, 14'h00FF, "R13");                            // single pulse only
        step(0, mk(5'b11111, 9'h000), "R2");
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r = $urandom;
            step(r[31:30] == 2'b00, r[CA_W-1:0], "");
        end
        @(negedge clk); rst = 1'b1; m_pend = 0;
        @(posedge clk); #1;
        check_bit("R1", cmd_valid, 1'b0, "valid after late reset");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule